// File: doc/BRIEF.md
# Slot Status LED Blink Controller

This block drives the status indicators of a bank of card slots. Each slot has a green LED and an amber LED. Each LED takes its behaviour from a two-bit mode field that software writes: dark, lit, or blinking in one of two opposite phases. A single divider counts bus clock cycles to form a one-second blink period with a 50% duty cycle. Every blinking LED in the bank follows that one reference, so LEDs set to opposite phases alternate exactly.

Each slot also has a mechanical open indication. When a slot's open signal rises, the block clears both of that slot's mode fields, so the slot goes dark without any action from software. Software can rewrite the fields afterwards, whether or not the slot is still open.

Writes arrive on a simple strobe port. The port carries a slot index and a four-bit value. The green mode sits in bits [1:0] of that value and the amber mode in bits [3:2]. The asynchronous active-low reset passes through a two-stage synchronizer. The block therefore leaves reset on the second clock edge after `rst_n` rises, and the blink divider begins counting on the third edge.

Top module: `slot_led_ctrl`

## Requirements
- R1: While the block is in reset, and directly after it leaves reset, every mode field is 00 and every LED output is 0.
- R2: Mode values are encoded as follows: 00 holds the LED at 0, 01 holds it at 1, 10 selects blink phase A, and 11 selects blink phase B.
- R3: An LED in mode 10 is lit for the first HALF_PERIOD_CYCLES cycles of each blink period and dark for the second half, counted from the first edge after the block leaves reset.
- R4: An LED in mode 11 is lit exactly when an LED in mode 10 is dark, so the two phases never light together.
- R5: The blink period is 2*HALF_PERIOD_CYCLES bus clock cycles. A single divider times every blinking LED in the bank.
- R6: A write with wr_en high loads wr_data into the mode fields of slot wr_slot on the next clock edge and leaves every other slot unchanged. A write whose slot index is NUM_SLOTS or more changes nothing.
- R7: A rising edge on slot_open[i] clears both mode fields of slot i on the next clock edge, so both of its LEDs go to 0.
- R8: While slot_open[i] stays high after its rising edge, a write to slot i takes effect normally and is not cleared again.
- R9: If a write to slot i and a rising edge of slot_open[i] occur in the same cycle, the slot's modes become 00.
- R10: The green mode is taken from wr_data[1:0] and the amber mode from wr_data[3:2]. The two are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode write strobe |
| wr_slot | input | SLOT_W | Slot index of the write |
| wr_data | input | 4 | Amber mode in [3:2], green mode in [1:0] |
| slot_open | input | NUM_SLOTS | Per-slot open indication, active high |
| led_green | output | NUM_SLOTS | Green LED drive per slot, 1 = lit |
| led_amber | output | NUM_SLOTS | Amber LED drive per slot, 1 = lit |

## Verification
A wrong mode field appears on that slot's LED pins in the cycle after the faulty update. A field that is stuck or misplaced is caught at once if its true value is steady. If the field is blinking, the fault shows within one half period. A divider that miscounts shifts the phase boundary, so any LED in a blink mode disagrees with the arithmetic model within one period. A missed or repeated open-clear shows as a lit LED, or a dark one, on the cycle after the edge.

// File: rtl/slot_led_pkg.sv
package slot_led_pkg;

  typedef enum logic [1:0] {
    LED_DARK    = 2'b00,
    LED_LIT     = 2'b01,
    LED_PHASE_A = 2'b10,
    LED_PHASE_B = 2'b11
  } led_mode_e;

  typedef struct packed {
    led_mode_e amber;
    led_mode_e green;
  } slot_modes_t;

  localparam int MODE_BITS = $bits(slot_modes_t);

  function automatic logic mode_lit(led_mode_e mode, logic second_half);
    logic lit;
    case (mode)
      LED_LIT:     lit = 1'b1;
      LED_PHASE_A: lit = ~second_half;
      LED_PHASE_B: lit = second_half;
      default:     lit = 1'b0;
    endcase
    return lit;
  endfunction

endpackage

// File: rtl/slot_led_rst_sync.sv
module slot_led_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/slot_led_blink_timer.sv
module slot_led_blink_timer #(
  parameter int HALF_PERIOD_CYCLES = 33_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic second_half
);

  localparam int CNT_W = (HALF_PERIOD_CYCLES > 1) ? $clog2(HALF_PERIOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(HALF_PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;
  logic             at_term;

  always_comb begin
    at_term = (cnt_q == TERM);
    cnt_d   = at_term ? '0 : cnt_q + 1'b1;
    half_d  = at_term ? ~half_q : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign second_half = half_q;

  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);

  p_phase_flip_at_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_q) |-> $past(cnt_q) == TERM);

endmodule

// File: rtl/slot_led_slot_regs.sv
module slot_led_slot_regs
  import slot_led_pkg::*;
#(
  parameter int SLOT_IDX = 0,
  parameter int SLOT_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic [MODE_BITS-1:0] wr_data,
  input  logic                 open_in,
  output slot_modes_t          modes
);

  slot_modes_t modes_q, modes_d;
  logic        open_q;
  logic        open_rise;
  logic        hit;

  always_comb begin
    open_rise = open_in & ~open_q;
    hit       = wr_en & (wr_slot == SLOT_W'(SLOT_IDX));
    modes_d   = modes_q;
    if (hit)       modes_d = slot_modes_t'(wr_data);
    if (open_rise) modes_d = '{amber: LED_DARK, green: LED_DARK};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modes_q <= '{amber: LED_DARK, green: LED_DARK};
      open_q  <= 1'b0;
    end else begin
      modes_q <= modes_d;
      open_q  <= open_in;
    end
  end

  assign modes = modes_q;

  p_open_edge_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_in && !open_q) |=> (modes_q == slot_modes_t'('0)));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == SLOT_W'(SLOT_IDX) && !(open_in && !open_q))
      |=> (modes_q == slot_modes_t'($past(wr_data))));

  p_no_write_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_slot == SLOT_W'(SLOT_IDX)) && !(open_in && !open_q)) |=> $stable(modes_q));

endmodule

// File: rtl/slot_led_ctrl.sv
module slot_led_ctrl
  import slot_led_pkg::*;
#(
  parameter int NUM_SLOTS          = 6,
  parameter int HALF_PERIOD_CYCLES = 33_000_000,
  parameter int SLOT_W             = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic [MODE_BITS-1:0] wr_data,
  input  logic [NUM_SLOTS-1:0] slot_open,
  output logic [NUM_SLOTS-1:0] led_green,
  output logic [NUM_SLOTS-1:0] led_amber
);

  logic        rst_n_int;
  logic        second_half;
  slot_modes_t slot_modes [NUM_SLOTS];

  slot_led_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  slot_led_blink_timer #(.HALF_PERIOD_CYCLES(HALF_PERIOD_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .second_half(second_half)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_led_slot_regs #(.SLOT_IDX(s), .SLOT_W(SLOT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .wr_en  (wr_en),
      .wr_slot(wr_slot),
      .wr_data(wr_data),
      .open_in(slot_open[s]),
      .modes  (slot_modes[s])
    );

    always_comb begin
      led_green[s] = mode_lit(slot_modes[s].green, second_half);
      led_amber[s] = mode_lit(slot_modes[s].amber, second_half);
    end

    p_phases_opposite_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
      (slot_modes[s].green == LED_PHASE_A && slot_modes[s].amber == LED_PHASE_B)
        |-> (led_green[s] != led_amber[s]));

    p_dark_after_open_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
      $rose(slot_open[s]) |=> (!led_green[s] && !led_amber[s]));
  end

  p_reset_dark_r1: assert property (@(posedge clk)
    !rst_n_int |-> (led_green == '0 && led_amber == '0));

endmodule

// File: tb/slot_led_ctrl_tb.sv
module slot_led_ctrl_tb;

  localparam int NS = 6;
  localparam int HP = 4;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [3:0]    wr_data = '0;
  logic [NS-1:0] slot_open = '0;
  logic [NS-1:0] led_green;
  logic [NS-1:0] led_amber;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  logic [1:0] mg [NS];
  logic [1:0] ma [NS];

  slot_led_ctrl #(.NUM_SLOTS(NS), .HALF_PERIOD_CYCLES(HP), .SLOT_W(SW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_data  (wr_data),
    .slot_open(slot_open),
    .led_green(led_green),
    .led_amber(led_amber)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic logic exp_half();
    int k;
    k = (edges > 2) ? edges - 2 : 0;
    return ((k / HP) % 2) == 1;
  endfunction

  function automatic logic exp_lit(logic [1:0] m, logic h);
    case (m)
      2'b01:   return 1'b1;
      2'b10:   return ~h;
      2'b11:   return h;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_leds(string req);
    logic h;
    h = exp_half();
    for (int s = 0; s < NS; s++) begin
      checks++;
      if (led_green[s] !== exp_lit(mg[s], h)) begin
        errors++;
        $display("FAIL %s slot %0d green: got %b expected %b", req, s, led_green[s], exp_lit(mg[s], h));
      end
      checks++;
      if (led_amber[s] !== exp_lit(ma[s], h)) begin
        errors++;
        $display("FAIL %s slot %0d amber: got %b expected %b", req, s, led_amber[s], exp_lit(ma[s], h));
      end
    end
  endtask

  task automatic do_write(int slot, logic [3:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(slot); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (slot < NS) begin
      mg[slot] = data[1:0];
      ma[slot] = data[3:2];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin mg[s] = 2'b00; ma[s] = 2'b00; end
    repeat (5) @(negedge clk);
    check_leds("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_leds("R1");

    // R2 R10: every code on every slot, watched over a full blink period
    for (int s = 0; s < NS; s++) begin
      for (int d = 0; d < 16; d++) begin
        do_write(s, 4'(d));
        for (int c = 0; c < 2 * HP; c++) begin
          check_leds("R2_R10");
          @(negedge clk);
        end
      end
    end

    // R3 R4 R5: opposite phases on one slot, long run
    do_write(0, 4'b1110);
    do_write(1, 4'b1011);
    do_write(2, 4'b1101);
    for (int c = 0; c < 6 * HP; c++) begin
      check_leds("R3_R4_R5");
      @(negedge clk);
    end

    // R6: out-of-range slot indices change nothing
    do_write(6, 4'hF);
    check_leds("R6");
    do_write(7, 4'h5);
    check_leds("R6");

    // R7: rising open edge clears the slot
    for (int s = 0; s < NS; s++) do_write(s, 4'h5);
    @(negedge clk);
    slot_open[2] = 1'b1;
    @(negedge clk);
    mg[2] = 2'b00; ma[2] = 2'b00;
    check_leds("R7");

    // R8: rewrite while open sticks
    do_write(2, 4'h5);
    check_leds("R8");
    repeat (3) @(negedge clk);
    check_leds("R8");
    do_write(2, 4'b1110);
    for (int c = 0; c < 2 * HP; c++) begin
      check_leds("R8");
      @(negedge clk);
    end

    // R9: write and open edge together, open wins
    slot_open[3] = 1'b1;
    wr_en = 1'b1; wr_slot = 3'd3; wr_data = 4'hF;
    @(negedge clk);
    wr_en = 1'b0;
    mg[3] = 2'b00; ma[3] = 2'b00;
    check_leds("R9");

    // R7: second open edge after release clears again
    slot_open[2] = 1'b0;
    do_write(2, 4'h5);
    check_leds("R7");
    slot_open[2] = 1'b1;
    @(negedge clk);
    mg[2] = 2'b00; ma[2] = 2'b00;
    check_leds("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule